// File: doc/BRIEF.md
# Segmented Carry-Predicting Approximate Adder

This block adds two unsigned N-bit operands approximately, with no clock. The operands are cut into N/K slices of K bits each. Every slice has its own small ripple adder, and all slices work at the same time. A slice does not wait for the carry from the slice below it. Instead, that carry is guessed from a few of the highest bit pairs of the lower slice, and this guess settles within two gate levels. The longest path is therefore one K-bit ripple plus a short predictor, not a full N-bit carry chain.

The guess looks at the top pair of the lower slice first, then at the pair just below it. With the parameter USE_RECT set, a correction stage also looks at the third and fourth pairs from the top. It is used only when the first two pairs both merely propagate. With USE_RECT clear, the predictor uses two pairs and needs K of at least 2. With USE_RECT set it needs K of at least 4. Elaboration stops if N is not a whole multiple of K, or if K is smaller than the chosen variant needs. The result is exact for most operand pairs. It is wrong when the true carry was born below the pairs that were inspected.

Top module: `sce_adder`

## Requirements
- R1: Each K-bit slice s of `sum_o` equals (slice s of `opnd_a` + slice s of `opnd_b` + predicted carry-in of slice s) modulo 2^K.
- R2: The predicted carry-in of the lowest slice is always 0. A carry out of a slice reaches the next slice only through the prediction rule, never through a carry chain.
- R3: If bit K-1 of the lower slice is 1 in both operands, the predicted carry is 1. If that bit is 0 in both operands, the predicted carry is 0.
- R4: If bit K-1 differs between the operands and bit K-2 is equal, the predicted carry equals bit K-2.
- R5: With USE_RECT=1, when bits K-1 and K-2 both differ, the predicted carry is computed by the R3/R4 rule applied to bits K-3 (in place of K-1) and K-4 (in place of K-2). If those two pairs also both differ, the predicted carry is 0.
- R6: With USE_RECT=0, when bits K-1 and K-2 both differ, the predicted carry is 0.
- R7: `carry_o` equals the carry predicted by the same rule from the upper bits of the highest slice.
- R8: The outputs are a pure function of the present operands. They are valid in the same clock period as the operands, and all-zero operands give a zero sum and a zero carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | N | First unsigned operand |
| opnd_b | input | N | Second unsigned operand |
| sum_o | output | N | Approximate sum |
| carry_o | output | 1 | Predicted carry out of the top slice |

## Verification
The block has no registers, so every result is due within the same bench clock period in which the operands are applied. The bench drives the operands just after a rising edge and reads `sum_o` and `carry_o` at the next falling edge. The logic has settled by then, and no edge ordering is involved. Directed cases cover each branch of the prediction rule, including a carry generated at bit 0 that is lost. Random operand pairs are then compared against an independent behavioural model for both the corrected and the plain variants. The bench also counts how often the result matches the exact sum.

// File: rtl/sce_pkg.sv
// Package sce_pkg
// Shared constants for the segmented approximate adder.
// Assumes: nothing beyond IEEE 1800-2017.
package sce_pkg;
    // Smallest slice width for each predictor variant.
    localparam int unsigned SCE_MIN_K_PLAIN = 2;
    localparam int unsigned SCE_MIN_K_RECT  = 4;

    // Number of bit pairs the predictor inspects for a given variant.
    function automatic int unsigned sce_pairs(input bit use_rect);
        return use_rect ? 4 : 2;
    endfunction
endpackage

// File: rtl/sce_carry_est.sv
// Module sce_carry_est
// Two-pair carry guess. The upper pair decides when it generates or kills.
// When it only propagates, the lower pair decides. When both pairs propagate, the guess is 0.
// Assumes: the inputs are the bits of two adjacent positions of the two operands.
module sce_carry_est (
    input  logic hi_a,
    input  logic hi_b,
    input  logic lo_a,
    input  logic lo_b,
    output logic est_o
);
    // Two-level guess: generate at the upper pair, or propagate there and generate below.
    always_comb begin
        est_o = (hi_a & hi_b) | ((hi_a ^ hi_b) & lo_a & lo_b);
    end
endmodule

// File: rtl/sce_carry_pick.sv
// Module sce_carry_pick
// Predicts the carry leaving one slice from that slice's top bit pairs.
// With USE_RECT set, a second guess over the next two pairs down is used
// when the top two pairs both propagate.
// Assumes: the inputs are the top HI_W bits of the slice, with the MSB at index HI_W-1.
module sce_carry_pick #(
    parameter bit USE_RECT = 1'b1,
    localparam int unsigned HI_W = sce_pkg::sce_pairs(USE_RECT)
) (
    input  logic [HI_W-1:0] hi_a,
    input  logic [HI_W-1:0] hi_b,
    output logic            carry_o
);
    logic est_top;

    sce_carry_est u_est_top (
        .hi_a  (hi_a[HI_W-1]),
        .hi_b  (hi_b[HI_W-1]),
        .lo_a  (hi_a[HI_W-2]),
        .lo_b  (hi_b[HI_W-2]),
        .est_o (est_top)
    );

    generate
        if (USE_RECT) begin : g_rect
            logic est_low;
            logic take_low;

            sce_carry_est u_est_low (
                .hi_a  (hi_a[HI_W-3]),
                .hi_b  (hi_b[HI_W-3]),
                .lo_a  (hi_a[HI_W-4]),
                .lo_b  (hi_b[HI_W-4]),
                .est_o (est_low)
            );

            // Selector: both top pairs propagate, so the lower guess is used.
            always_comb begin
                take_low = (hi_a[HI_W-1] ^ hi_b[HI_W-1]) & (hi_a[HI_W-2] ^ hi_b[HI_W-2]);
                carry_o  = take_low ? est_low : est_top;
            end

            // Check that the correction applies to the lower pairs when both top pairs propagate.
            always_comb begin
                if ((hi_a[HI_W-1] != hi_b[HI_W-1]) && (hi_a[HI_W-2] != hi_b[HI_W-2])
                    && (hi_a[HI_W-3] == hi_b[HI_W-3])) begin
                    assert_rect_hi_R5 : assert (carry_o == hi_a[HI_W-3])
                        else $error("R5: rectified carry mismatch");
                end
                if ((hi_a[HI_W-1] != hi_b[HI_W-1]) && (hi_a[HI_W-2] != hi_b[HI_W-2])
                    && (hi_a[HI_W-3] != hi_b[HI_W-3]) && (hi_a[HI_W-4] != hi_b[HI_W-4])) begin
                    assert_rect_default_R5 : assert (carry_o == 1'b0)
                        else $error("R5: default carry not zero");
                end
            end
        end else begin : g_plain
            // Without correction the top guess is final.
            always_comb begin
                carry_o = est_top;
            end

            // Check that the plain variant defaults to 0 when both top pairs propagate.
            always_comb begin
                if ((hi_a[1] != hi_b[1]) && (hi_a[0] != hi_b[0])) begin
                    assert_plain_default_R6 : assert (carry_o == 1'b0)
                        else $error("R6: plain default carry not zero");
                end
            end
        end
    endgenerate

    // Check that the top pair decides whenever it generates or kills.
    always_comb begin
        if (hi_a[HI_W-1] == hi_b[HI_W-1]) begin
            assert_top_pair_R3 : assert (carry_o == hi_a[HI_W-1])
                else $error("R3: top pair rule broken");
        end
        if ((hi_a[HI_W-1] != hi_b[HI_W-1]) && (hi_a[HI_W-2] == hi_b[HI_W-2])) begin
            assert_second_pair_R4 : assert (carry_o == hi_a[HI_W-2])
                else $error("R4: second pair rule broken");
        end
    end
endmodule

// File: rtl/sce_slice_add.sv
// Module sce_slice_add
// K-bit ripple adder for one slice. Its internal carry out is not used.
// Assumes: K >= 1. cin_i comes from the predictor of the slice below.
module sce_slice_add #(
    parameter int unsigned K = 8
) (
    input  logic [K-1:0] a_i,
    input  logic [K-1:0] b_i,
    input  logic         cin_i,
    output logic [K-1:0] sum_o
);
    // Ripple from the chosen carry-in through the slice bits.
    always_comb begin : p_ripple
        logic c;
        c = cin_i;
        for (int j = 0; j < K; j++) begin
            sum_o[j] = a_i[j] ^ b_i[j] ^ c;
            c        = (a_i[j] & b_i[j]) | ((a_i[j] ^ b_i[j]) & c);
        end
    end
endmodule

// File: rtl/sce_adder.sv
// Module sce_adder (top)
// Approximate unsigned adder. N bits are cut into N/K slices that all add at
// the same time. Each slice carry-in is predicted from the slice below.
// Assumes: N % K == 0, and K >= 4 with USE_RECT, K >= 2 without.
// Purely combinational.
module sce_adder #(
    parameter int unsigned N        = 32,
    parameter int unsigned K        = 8,
    parameter bit          USE_RECT = 1'b1
) (
    input  logic [N-1:0] opnd_a,
    input  logic [N-1:0] opnd_b,
    output logic [N-1:0] sum_o,
    output logic         carry_o
);
    localparam int unsigned SEGS  = N / K;
    localparam int unsigned MIN_K = USE_RECT ? sce_pkg::SCE_MIN_K_RECT : sce_pkg::SCE_MIN_K_PLAIN;
    localparam int unsigned HI_W  = sce_pkg::sce_pairs(USE_RECT);

    generate
        if ((N % K) != 0) begin : g_bad_split
            $error("sce_adder: N must be a multiple of K");
        end
        if (K < MIN_K) begin : g_bad_width
            $error("sce_adder: K below the minimum for this variant");
        end
    endgenerate

    logic [SEGS:0] seg_cin;

    // The lowest slice always starts from a zero carry.
    always_comb begin
        seg_cin[0] = 1'b0;
    end

    generate
        for (genvar s = 0; s < SEGS; s++) begin : g_seg
            localparam int unsigned LO = s * K;

            sce_slice_add #(.K(K)) u_add (
                .a_i   (opnd_a[LO +: K]),
                .b_i   (opnd_b[LO +: K]),
                .cin_i (seg_cin[s]),
                .sum_o (sum_o[LO +: K])
            );

            sce_carry_pick #(.USE_RECT(USE_RECT)) u_pick (
                .hi_a    (opnd_a[LO+K-1 -: HI_W]),
                .hi_b    (opnd_b[LO+K-1 -: HI_W]),
                .carry_o (seg_cin[s+1])
            );
        end
    endgenerate

    // The carry out comes from the top slice's predictor.
    always_comb begin
        carry_o = seg_cin[SEGS];
    end

    // Check that the lowest slice is an exact K-bit sum with no carry-in.
    always_comb begin
        assert_low_slice_R2 : assert (sum_o[K-1:0] == K'(opnd_a[K-1:0] + opnd_b[K-1:0]))
            else $error("R2: lowest slice not a zero-carry sum");
    end

    // Check that all-zero operands give all-zero outputs.
    always_comb begin
        if ((opnd_a == '0) && (opnd_b == '0)) begin
            assert_zero_in_R8 : assert ((sum_o == '0) && (carry_o == 1'b0))
                else $error("R8: zero operands gave nonzero output");
        end
    end
endmodule

// File: tb/sce_adder_bench.sv
// Directed and random checks of sce_adder. The corrected (USE_RECT=1) and
// plain (USE_RECT=0) variants are both instantiated with N=32, K=8.
module sce_adder_bench;
    localparam int unsigned N = 32;
    localparam int unsigned K = 8;
    localparam int unsigned S = N / K;

    logic clk = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic [N-1:0] a, b;
    logic [N-1:0] sum_r, sum_p;
    logic         co_r, co_p;

    int total = 0;
    int bad   = 0;
    int exact_hits = 0;
    bit done = 1'b0;

    sce_adder #(.N(N), .K(K), .USE_RECT(1'b1)) u_sce_adder (
        .opnd_a(a), .opnd_b(b), .sum_o(sum_r), .carry_o(co_r));

    sce_adder #(.N(N), .K(K), .USE_RECT(1'b0)) u_sce_adder_plain (
        .opnd_a(a), .opnd_b(b), .sum_o(sum_p), .carry_o(co_p));

    // Independent model: the carry guess is written as "equal pair decides".
    function automatic logic guess(input logic [N-1:0] x, input logic [N-1:0] y,
                                   input int top, input bit rect);
        int depth = rect ? 4 : 2;
        for (int d = 0; d < depth; d++) begin
            if (x[top-d] == y[top-d]) return x[top-d];
        end
        return 1'b0;
    endfunction

    function automatic logic [N:0] model(input logic [N-1:0] x, input logic [N-1:0] y,
                                         input bit rect);
        logic [N-1:0] s = '0;
        logic         c = 1'b0;
        for (int g = 0; g < int'(S); g++) begin
            logic [K:0] part = {1'b0, x[g*K +: K]} + {1'b0, y[g*K +: K]} + {{K{1'b0}}, c};
            s[g*K +: K] = part[K-1:0];
            c = guess(x, y, g*K + K - 1, rect);
        end
        return {c, s};
    endfunction

    task automatic check(input string req, input logic [N:0] got, input logic [N:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s a=%h b=%h got=%h exp=%h", req, a, b, got, exp);
        end
    endtask

    // Drive after a rising edge and sample at the falling edge of the same period.
    task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y);
        @(posedge clk);
        a = x;
        b = y;
        @(negedge clk);
    endtask

    task automatic t_zero();
        apply('0, '0);
        check("R8 zero rect", {co_r, sum_r}, '0);
        check("R8 zero plain", {co_p, sum_p}, '0);
    endtask

    task automatic t_top_pair();
        apply(32'h0000_0080, 32'h0000_0080);   // bit 7 generates
        check("R3 generate", {co_r, sum_r}, {1'b0, 32'h0000_0100});
        apply(32'h0000_007F, 32'h0000_0001);   // bit 7 kills
        check("R3 kill", {co_r, sum_r}, {1'b0, 32'h0000_0080});
    endtask

    task automatic t_second_pair();
        apply(32'h0000_00C0, 32'h0000_0040);   // bit 7 propagates, bit 6 generates
        check("R4 one", {co_r, sum_r}, {1'b0, 32'h0000_0100});
        apply(32'h0000_0080, 32'h0000_0000);   // bit 7 propagates, bit 6 kills
        check("R4 zero", {co_r, sum_r}, {1'b0, 32'h0000_0080});
    endtask

    task automatic t_rect();
        apply(32'h0000_00A0, 32'h0000_0060);   // bits 7,6 propagate, bit 5 generates
        check("R5 rect used", {co_r, sum_r}, {1'b0, 32'h0000_0100});
        check("R6 plain default", {co_p, sum_p}, {1'b0, 32'h0000_0000});
    endtask

    task automatic t_lost_carry();
        apply(32'h0000_00FF, 32'h0000_0001);   // carry born at bit 0 is lost
        check("R2 lost rect", {co_r, sum_r}, {1'b0, 32'h0000_0000});
        check("R2 lost plain", {co_p, sum_p}, {1'b0, 32'h0000_0000});
        apply(32'h0000_0055, 32'h0000_00AB);
        check("R5 all propagate", {co_r, sum_r}, {1'b0, 32'h0000_0000});
    endtask

    task automatic t_carry_out();
        apply(32'h8000_0000, 32'h8000_0000);
        check("R7 top generate", {co_r, sum_r}, {1'b1, 32'h0000_0000});
        apply(32'hA000_0000, 32'h6000_0000);
        check("R7 top rect", {co_r, sum_r}, {1'b1, 32'h0000_0000});
        check("R7 top plain", {co_p, sum_p}, {1'b0, 32'h0000_0000});
    endtask

    task automatic t_multi_slice();
        apply(32'h1234_5678, 32'h1111_1111);
        check("R1 mixed rect", {co_r, sum_r}, model(a, b, 1'b1));
        check("R1 mixed plain", {co_p, sum_p}, model(a, b, 1'b0));
    endtask

    task automatic t_random();
        for (int i = 0; i < 300; i++) begin
            logic [N:0] ex;
            apply($urandom(), $urandom());
            check("R1 random rect", {co_r, sum_r}, model(a, b, 1'b1));
            check("R1 random plain", {co_p, sum_p}, model(a, b, 1'b0));
            ex = {1'b0, a} + {1'b0, b};
            if ({co_r, sum_r} == ex) exact_hits++;
        end
        $display("exact matches (rect): %0d of 300", exact_hits);
    endtask

    initial begin
        a = '0;
        b = '0;
        t_zero();
        t_top_pair();
        t_second_pair();
        t_rect();
        t_lost_carry();
        t_carry_out();
        t_multi_slice();
        t_random();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired got=hang exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule